// File: doc/BRIEF.md
# Core Idle-Entry Sequencer

This block walks a processor core into a low-power idle state and back out again. Decode raises a one-cycle request when it meets an idle instruction. The request is honoured only while the core runs with supervisor privilege. Once honoured, the sequencer makes the pipeline fill with no-operations until the next sync instruction has been issued and the system side has acknowledged it. It then raises its idle indication and waits until every source of pending activity is quiet. Only then does it drop the enable of the core clock.

The sequencer runs on a clock that is never gated, so it still sees the wakeup line while the core clock is stopped. The wakeup line is asynchronous and passes through a synchronizer chain. A wakeup that arrives while the pipeline is still draining, or while activity is still pending, is held so that it is not lost. Wakeup is the only way out of idle. On exit the clock enable comes back, and a single-cycle completion pulse tells decode that the outstanding sync has retired, so execution resumes at the next instruction with supervisor mode reported to the core.

Top module: `idle_seq_ctrl`

## Requirements
- R1: An idle request made while `supv_i` is low is ignored: `nop_inj_o`, `idle_o` and `core_clk_en_o` keep their running values (0, 0, 1).
- R2: An idle request made while `supv_i` is high raises `nop_inj_o` in the cycle after the request. It stays high until the cycle after a sync acknowledge is accepted, and then falls.
- R3: `sync_ack_i` is accepted only when a sync request was seen in the same cycle or in an earlier cycle of the drain phase. An acknowledge with no sync request behind it has no effect. `idle_o` rises in the cycle after an accepted acknowledge.
- R4: `core_clk_en_o` stays high while `idle_o` is high and any bit of `busy_i` is set. It falls in the cycle after all bits of `busy_i` are zero.
- R5: Only the wakeup line ends idle. While the clock is stopped, idle requests, sync requests, acknowledges and activity have no effect. A wakeup while the core is running has no effect.
- R6: On exit, for exactly one cycle, `sync_done_o` is 1, `core_clk_en_o` is 1, and `idle_o` and `nop_inj_o` are 0. Normal running follows.
- R7: `resume_supv_o` is 1 in the cycle of the completion pulse and 0 otherwise.
- R8: A wakeup pulse that is seen during the drain or quiet phase is held. The exit then follows one cycle after the clock stops, even if the line has already fallen.
- R9: A synchronous reset gives `core_clk_en_o`=1 and `idle_o`=`nop_inj_o`=`sync_done_o`=`resume_supv_o`=0, from any phase.
- R10: When the clock is stopped, a wakeup driven between edges produces the completion pulse after SYNC_STAGES+1 rising edges. Until then `core_clk_en_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, never gated |
| rst | input | 1 | Synchronous reset, active high |
| idle_req_i | input | 1 | Idle request strobe from decode |
| supv_i | input | 1 | Core is in supervisor mode |
| sync_req_i | input | 1 | Sync instruction issued |
| sync_ack_i | input | 1 | Sync acknowledge from the system side |
| busy_i | input | N_SRC | Pending-activity flags, one per source |
| wake_i | input | 1 | Asynchronous wakeup line |
| idle_o | output | 1 | Core is in idle |
| core_clk_en_o | output | 1 | Enable for the core clock |
| nop_inj_o | output | 1 | Fill the pipeline with no-operations |
| sync_done_o | output | 1 | One-cycle completion of the outstanding sync |
| resume_supv_o | output | 1 | Mode reported on resume is supervisor |

## Verification
Two pairs of events can land in the same cycle. In the first, a sync request and its acknowledge arrive together. The bench drives both at one edge and expects `idle_o` on the next, and it also drives a lone acknowledge first, which must be ignored. In the second, a wakeup arrives while draining or while activity is still pending, so it overlaps with the entry into the stopped-clock phase. The bench sweeps the acknowledge delay, the length of the busy phase and the wakeup timing. It computes the exit edge arithmetically as the later of one edge after the clock stops and SYNC_STAGES+1 edges after the wakeup is raised.

// File: rtl/idle_seq_pkg.sv
package idle_seq_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_DRAIN = 3'd1,
        ST_QUIET = 3'd2,
        ST_SLEEP = 3'd3,
        ST_WAKE  = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       sync_seen;
        logic       wake_pend;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RESET = '{state: ST_RUN, sync_seen: 1'b0, wake_pend: 1'b0};

endpackage

// File: rtl/idle_wake_sync.sv
module idle_wake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/idle_seq_fsm.sv
module idle_seq_fsm
    import idle_seq_pkg::*;
#(
    parameter int N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle_req_i,
    input  logic             supv_i,
    input  logic             sync_req_i,
    input  logic             sync_ack_i,
    input  logic [N_SRC-1:0] busy_i,
    input  logic             wake_s_i,
    output logic             idle_o,
    output logic             core_clk_en_o,
    output logic             nop_inj_o,
    output logic             sync_done_o,
    output logic             resume_supv_o,
    output logic             wake_pend_o
);

    seq_regs_t r_d, r_q;
    logic      any_busy;

    assign any_busy = |busy_i;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_RUN: begin
                r_d.sync_seen = 1'b0;
                r_d.wake_pend = 1'b0;
                if (idle_req_i && supv_i) r_d.state = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (wake_s_i)   r_d.wake_pend = 1'b1;
                if (sync_req_i) r_d.sync_seen = 1'b1;
                if (sync_ack_i && (r_q.sync_seen || sync_req_i)) begin
                    r_d.state     = ST_QUIET;
                    r_d.sync_seen = 1'b0;
                end
            end
            ST_QUIET: begin
                if (wake_s_i) r_d.wake_pend = 1'b1;
                if (!any_busy) r_d.state = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (wake_s_i || r_q.wake_pend) begin
                    r_d.state     = ST_WAKE;
                    r_d.wake_pend = 1'b0;
                end
            end
            ST_WAKE: begin
                r_d.state = ST_RUN;
            end
            default: r_d = SEQ_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= SEQ_RESET;
        else     r_q <= r_d;
    end

    always_comb begin
        idle_o        = (r_q.state == ST_QUIET) || (r_q.state == ST_SLEEP);
        core_clk_en_o = (r_q.state != ST_SLEEP);
        nop_inj_o     = (r_q.state == ST_DRAIN);
        sync_done_o   = (r_q.state == ST_WAKE);
        resume_supv_o = (r_q.state == ST_WAKE);
    end

    assign wake_pend_o = r_q.wake_pend;

endmodule

// File: rtl/idle_seq_ctrl.sv
module idle_seq_ctrl #(
    parameter int N_SRC       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle_req_i,
    input  logic             supv_i,
    input  logic             sync_req_i,
    input  logic             sync_ack_i,
    input  logic [N_SRC-1:0] busy_i,
    input  logic             wake_i,
    output logic             idle_o,
    output logic             core_clk_en_o,
    output logic             nop_inj_o,
    output logic             sync_done_o,
    output logic             resume_supv_o
);

    logic wake_s;
    logic wake_pend;

    idle_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (wake_i),
        .sync_o  (wake_s)
    );

    idle_seq_fsm #(.N_SRC(N_SRC)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .idle_req_i    (idle_req_i),
        .supv_i        (supv_i),
        .sync_req_i    (sync_req_i),
        .sync_ack_i    (sync_ack_i),
        .busy_i        (busy_i),
        .wake_s_i      (wake_s),
        .idle_o        (idle_o),
        .core_clk_en_o (core_clk_en_o),
        .nop_inj_o     (nop_inj_o),
        .sync_done_o   (sync_done_o),
        .resume_supv_o (resume_supv_o),
        .wake_pend_o   (wake_pend)
    );

endmodule

// File: rtl/idle_seq_chk.sv
module idle_seq_chk #(
    parameter int N_SRC = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             idle_req_i,
    input logic             supv_i,
    input logic             sync_ack_i,
    input logic [N_SRC-1:0] busy_i,
    input logic             idle_o,
    input logic             core_clk_en_o,
    input logic             nop_inj_o,
    input logic             sync_done_o,
    input logic             resume_supv_o,
    input logic             wake_s,
    input logic             wake_pend
);

    logic running;
    assign running = !nop_inj_o && !idle_o && core_clk_en_o && !sync_done_o;

    p_user_ignored_r1: assert property (@(posedge clk) disable iff (rst)
        (running && idle_req_i && !supv_i) |=> !nop_inj_o);

    p_nop_start_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(nop_inj_o) |-> $past(idle_req_i && supv_i));

    p_idle_after_ack_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(idle_o) |-> ($past(sync_ack_i) && !nop_inj_o));

    p_clk_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(core_clk_en_o) |-> $past(idle_o && (busy_i == '0)));

    p_exit_wake_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(idle_o) |-> $past(wake_s || wake_pend));

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        sync_done_o |=> !sync_done_o);

    p_done_from_sleep_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_done_o) |-> $past(!core_clk_en_o));

    p_supv_resume_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(resume_supv_o) |-> $past(idle_o));

    p_wake_held_r8: assert property (@(posedge clk) disable iff (rst)
        (wake_s && nop_inj_o) |=> wake_pend);

endmodule

bind idle_seq_ctrl idle_seq_chk #(.N_SRC(N_SRC)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .idle_req_i    (idle_req_i),
    .supv_i        (supv_i),
    .sync_ack_i    (sync_ack_i),
    .busy_i        (busy_i),
    .idle_o        (idle_o),
    .core_clk_en_o (core_clk_en_o),
    .nop_inj_o     (nop_inj_o),
    .sync_done_o   (sync_done_o),
    .resume_supv_o (resume_supv_o),
    .wake_s        (wake_s),
    .wake_pend     (wake_pend)
);

// File: tb/sim_idle_seq_ctrl.sv
module sim_idle_seq_ctrl;
    localparam int N_SRC  = 3;
    localparam int STAGES = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst = 1'b1;
    logic             idle_req = 1'b0, supv = 1'b0, sync_req = 1'b0, sync_ack = 1'b0;
    logic [N_SRC-1:0] busy = '0;
    logic             wake = 1'b0;
    logic             idle_o, clk_en_o, nop_o, done_o, supv_o;

    int checks = 0;
    int errors = 0;
    int edges  = 0;
    bit wake_one = 1'b0;

    idle_seq_ctrl #(.N_SRC(N_SRC), .SYNC_STAGES(STAGES)) u0 (
        .clk(clk), .rst(rst), .idle_req_i(idle_req), .supv_i(supv),
        .sync_req_i(sync_req), .sync_ack_i(sync_ack), .busy_i(busy), .wake_i(wake),
        .idle_o(idle_o), .core_clk_en_o(clk_en_o), .nop_inj_o(nop_o),
        .sync_done_o(done_o), .resume_supv_o(supv_o)
    );

    task automatic cyc();
        @(posedge clk);
        edges++;
        #1;
        if (wake_one) begin
            wake = 1'b0;
            wake_one = 1'b0;
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_run(input string req);
        chk(req, "idle_o", int'(idle_o), 0);
        chk(req, "core_clk_en_o", int'(clk_en_o), 1);
        chk(req, "nop_inj_o", int'(nop_o), 0);
        chk(req, "sync_done_o", int'(done_o), 0);
        chk(req, "resume_supv_o", int'(supv_o), 0);
    endtask

    task automatic run_seq(input int ackdly, input int qd, input bit early, input bit same);
        int es;
        int e0;
        int target;
        string xr;
        e0 = 0;
        xr = early ? "R8" : "R6";
        idle_req = 1'b1; supv = 1'b1;
        cyc();
        idle_req = 1'b0; supv = 1'b0;
        chk("R2", "nop after request", int'(nop_o), 1);
        chk("R2", "idle during drain", int'(idle_o), 0);
        if (early) begin
            wake = 1'b1; wake_one = 1'b1; e0 = edges;
        end
        busy = (qd > 0) ? 3'b101 : 3'b000;
        if (!same) begin
            sync_req = 1'b1;
            cyc();
            sync_req = 1'b0;
            chk("R3", "idle before ack", int'(idle_o), 0);
            chk("R2", "nop held", int'(nop_o), 1);
        end
        for (int d = 0; d < ackdly; d++) begin
            if (same && d == 0) sync_ack = 1'b1;  // lone ack, no sync seen yet
            cyc();
            sync_ack = 1'b0;
            chk("R3", "idle before accepted ack", int'(idle_o), 0);
            chk("R2", "nop until ack", int'(nop_o), 1);
        end
        sync_ack = 1'b1;
        if (same) sync_req = 1'b1;
        cyc();
        sync_ack = 1'b0; sync_req = 1'b0;
        chk("R3", "idle after ack", int'(idle_o), 1);
        chk("R2", "nop off after ack", int'(nop_o), 0);
        chk("R4", "clk en while quiet wait", int'(clk_en_o), 1);
        for (int q = 0; q < qd; q++) begin
            cyc();
            chk("R4", "clk en while busy", int'(clk_en_o), 1);
        end
        busy = '0;
        cyc();
        es = edges;
        chk("R4", "clk en after quiet", int'(clk_en_o), 0);
        chk("R4", "idle in sleep", int'(idle_o), 1);
        if (!early) begin
            for (int k = 0; k < 3; k++) begin
                idle_req = 1'b1; supv = 1'b1; sync_ack = 1'b1; sync_req = 1'b1; busy = '1;
                cyc();
                chk("R5", "clk en in sleep", int'(clk_en_o), 0);
                chk("R5", "idle in sleep", int'(idle_o), 1);
            end
            idle_req = 1'b0; supv = 1'b0; sync_ack = 1'b0; sync_req = 1'b0; busy = '0;
            wake = 1'b1; e0 = edges;
        end
        target = (es + 1 > e0 + STAGES + 1) ? es + 1 : e0 + STAGES + 1;
        while (edges < target) begin
            cyc();
            if (edges < target) chk("R10", "clk en before wake edge", int'(clk_en_o), 0);
        end
        wake = 1'b0;
        chk(xr, "sync_done_o on exit", int'(done_o), 1);
        chk(xr, "clk en on exit", int'(clk_en_o), 1);
        chk("R6", "idle on exit", int'(idle_o), 0);
        chk("R6", "nop on exit", int'(nop_o), 0);
        chk("R7", "resume_supv_o on exit", int'(supv_o), 1);
        cyc();
        chk_run("R6");
        for (int k = 0; k < STAGES + 2; k++) begin
            cyc();
            chk_run("R5");
        end
    endtask

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        chk_run("R9");

        // user-mode request ignored
        idle_req = 1'b1; supv = 1'b0;
        cyc();
        idle_req = 1'b0;
        for (int k = 0; k < 4; k++) begin
            sync_req = (k == 1); sync_ack = (k == 1);
            cyc();
            chk_run("R1");
        end
        sync_req = 1'b0; sync_ack = 1'b0;

        // wakeup while running ignored
        wake = 1'b1;
        for (int k = 0; k < 3; k++) begin
            cyc();
            chk_run("R5");
        end
        wake = 1'b0;
        for (int k = 0; k < STAGES + 3; k++) begin
            cyc();
            chk_run("R5");
        end

        for (int a = 0; a < 4; a++)
            for (int q = 0; q < 4; q++)
                for (int e = 0; e < 2; e++)
                    for (int s = 0; s < 2; s++)
                        run_seq(a, q, e[0], s[0]);

        // reset while the clock is stopped
        idle_req = 1'b1; supv = 1'b1;
        cyc();
        idle_req = 1'b0; supv = 1'b0; sync_req = 1'b1; sync_ack = 1'b1;
        cyc();
        sync_req = 1'b0; sync_ack = 1'b0;
        cyc();
        chk("R9", "clk en stopped before reset", int'(clk_en_o), 0);
        rst = 1'b1;
        cyc();
        rst = 1'b0;
        chk_run("R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule